// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block owns every refresh operation of an asynchronous DRAM whose rows are refreshed by an internal row counter, triggered by pulling the column strobe low ahead of the row strobe. After reset it waits a start-up pause and issues a short burst of such refresh cycles, then reports that the memory is ready. From then on a free-running interval timer produces one refresh each interval. The row and column strobes are shared with an access controller. The sequencer asks for the strobes with a request line, waits for a grant, and lets the access controller have them back when it goes idle.

If the grant is withheld, overdue refreshes accumulate up to a limit and are issued back to back once the grant arrives. On a host request the sequencer puts the memory into self-refresh. It first runs one ordinary refresh, then drops the column strobe and, after a setup count, the row strobe, and holds both low. It stays there at least a minimum time and for as long as the request stays high. On exit it keeps the row strobe high for the longer self-refresh precharge time, then runs one more ordinary refresh before it drops busy.

All intervals are counts of clock cycles set by parameters. A refresh row-strobe pulse is always shorter than the lower edge of a forbidden zone. A self-refresh pulse is always at least the minimum self-refresh time, so no row-strobe low period ever ends inside the zone.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, rasN and casN are 1, refReq is 0, initDone is 0 and inSelf is 0; busy is 1 from reset until the first idle state.
- R2: After reset no strobe moves for at least INIT_PAUSE cycles; exactly INIT_CYCLES refresh cycles then follow, and initDone rises at the end of the last one and stays high.
- R3: In every refresh cycle casN goes low CAS_SETUP cycles before rasN falls and rises CAS_HOLD cycles after rasN falls. A refresh rasN low pulse lasts RAS_LOW cycles, and rasN stays high at least PRECHARGE cycles before the next casN fall.
- R4: Once initDone is high and the grant is held, exactly one refresh cycle is issued per REF_INTERVAL cycles.
- R5: refReq is high while the sequencer waits for or holds the strobes, and is 0 when it is idle. While it waits with grant low, rasN and casN stay high.
- R6: With the grant withheld, at most MAX_PENDING overdue refreshes are kept; when the grant arrives they are issued back to back, and no more than that.
- R7: A self-refresh request runs exactly one refresh cycle, then enters self-refresh with casN falling CAS_SETUP cycles before rasN. inSelf is high exactly while both strobes are held low. The hold lasts at least SELF_MIN cycles, and longer for as long as selfReq stays high.
- R8: No rasN low period ends with a length between ZONE_LO and SELF_MIN-1 cycles inclusive.
- R9: After self-refresh, rasN stays high at least SELF_PRECHARGE cycles before the next casN fall. Exactly one refresh cycle follows before busy falls, and busy is high throughout the self-refresh sequence.
- R10: selfReq has no effect before initDone is high: inSelf stays 0 and only short refresh pulses occur; a request still high when initDone rises is then served.
- R11: Two self-refresh periods are always separated by at least one ordinary refresh cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grant | input | 1 | Access controller hands over the strobes while high |
| selfReq | input | 1 | Host level request: high to enter and stay in self-refresh |
| refReq | output | 1 | Sequencer asks for or holds the strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| busy | output | 1 | Sequencer not idle (init, refresh or self-refresh sequence) |
| inSelf | output | 1 | Memory held in self-refresh |
| initDone | output | 1 | Start-up burst complete |

## Verification
Every strobe and status output is decoded from registered state, so each result shows up in the sample after the clock edge that changes the state. The bench samples on the falling clock edge and measures lengths as counts of those samples. A monitor counts consecutive low samples of each strobe. It checks the column setup count when the row strobe falls, the column hold count when the column strobe rises with the row strobe low, and the pulse length and zone rule when the row strobe rises. Interval and burst tests count row-strobe falls over windows sized from the parameters. Each window starts at a known event and has margin so that no timer tick falls on its edge. The start of a burst trails the first grant-high sample by one cycle, and an interval tick shows on refReq two cycles later.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [3:0] {
    ST_INIT_WAIT,
    ST_IDLE,
    ST_REQ,
    ST_CAS_SET,
    ST_RAS_ACT,
    ST_PRECH,
    ST_SELF_SET,
    ST_SELF_HOLD,
    ST_SELF_PRECH
  } refState_e;

  typedef enum logic [1:0] {
    PH_INIT,
    PH_NORM,
    PH_PRE,
    PH_POST
  } refPhase_e;

  typedef struct packed {
    logic cntClr;
    logic tmrHold;
    logic pendDec;
    logic initInc;
  } dpCtl_t;

endpackage

// File: rtl/ref_datapath.sv
module ref_datapath
  import dram_ref_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 1560,
  parameter int MAX_PENDING  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  output logic [CNT_W-1:0] phaseCnt,
  output logic             pendAny,
  output logic             pendMulti,
  output logic             initLast
);

  localparam int TMR_W  = $clog2(REF_INTERVAL + 1);
  localparam int PEND_W = $clog2(MAX_PENDING + 1);
  localparam int INIT_W = $clog2(INIT_CYCLES + 1);

  logic [TMR_W-1:0]  tmr;
  logic [PEND_W-1:0] pend;
  logic [INIT_W-1:0] initCnt;
  logic              tick;
  logic              incOk;

  // state-length counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClr) phaseCnt <= '0;
    else if (phaseCnt != '1) phaseCnt <= phaseCnt + 1'b1;
  end

  // distributed refresh interval timer
  assign tick = !ctl.tmrHold && (tmr == TMR_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rstN || ctl.tmrHold || tick) tmr <= '0;
    else tmr <= tmr + 1'b1;
  end

  // overdue refresh count; a tick at the limit is dropped unless one is served
  assign incOk = tick && ((pend != PEND_W'(MAX_PENDING)) || ctl.pendDec);

  always_ff @(posedge clk) begin
    if (!rstN || ctl.tmrHold) pend <= '0;
    else if (incOk && !ctl.pendDec) pend <= pend + 1'b1;
    else if (!incOk && ctl.pendDec && pend != '0) pend <= pend - 1'b1;
  end

  assign pendAny   = (pend != '0);
  assign pendMulti = (pend > PEND_W'(1));

  // start-up burst counter
  always_ff @(posedge clk) begin
    if (!rstN) initCnt <= '0;
    else if (ctl.initInc) initCnt <= initCnt + 1'b1;
  end

  assign initLast = (initCnt == INIT_W'(INIT_CYCLES - 1));

  assert_pend_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    pend <= PEND_W'(MAX_PENDING));

  assert_pend_flush_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.tmrHold |=> (pend == '0));

endmodule

// File: rtl/ref_control.sv
module ref_control
  import dram_ref_pkg::*;
#(
  parameter int CNT_W          = 16,
  parameter int INIT_PAUSE     = 20000,
  parameter int CAS_SETUP      = 2,
  parameter int CAS_HOLD       = 3,
  parameter int RAS_LOW        = 8,
  parameter int PRECHARGE      = 6,
  parameter int SELF_MIN       = 10000,
  parameter int SELF_PRECHARGE = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             grant,
  input  logic             selfReq,
  input  logic [CNT_W-1:0] phaseCnt,
  input  logic             pendAny,
  input  logic             pendMulti,
  input  logic             initLast,
  output dpCtl_t           ctl,
  output logic             refReq,
  output logic             rasN,
  output logic             casN,
  output logic             busy,
  output logic             inSelf,
  output logic             initDone
);

  refState_e state, stateNext;
  refPhase_e phase, phaseNext;
  logic      prechEnd;

  function automatic logic atEnd(input logic [CNT_W-1:0] cnt, input int len);
    return cnt == CNT_W'(len - 1);
  endfunction

  assign prechEnd = (state == ST_PRECH) && atEnd(phaseCnt, PRECHARGE);

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    case (state)
      ST_INIT_WAIT:
        if (atEnd(phaseCnt, INIT_PAUSE)) begin
          stateNext = ST_REQ;
          phaseNext = PH_INIT;
        end
      ST_IDLE:
        if (selfReq && initDone) begin
          stateNext = ST_REQ;
          phaseNext = PH_PRE;
        end else if (pendAny) begin
          stateNext = ST_REQ;
          phaseNext = PH_NORM;
        end
      ST_REQ:
        if (grant) stateNext = ST_CAS_SET;
      ST_CAS_SET:
        if (atEnd(phaseCnt, CAS_SETUP)) stateNext = ST_RAS_ACT;
      ST_RAS_ACT:
        if (atEnd(phaseCnt, RAS_LOW)) stateNext = ST_PRECH;
      ST_PRECH:
        if (prechEnd) begin
          case (phase)
            PH_INIT: begin
              stateNext = initLast ? ST_IDLE : ST_REQ;
              if (initLast) phaseNext = PH_NORM;
            end
            PH_NORM: stateNext = pendMulti ? ST_REQ : ST_IDLE;
            PH_PRE:  stateNext = ST_SELF_SET;
            default: begin
              stateNext = ST_IDLE;
              phaseNext = PH_NORM;
            end
          endcase
        end
      ST_SELF_SET:
        if (atEnd(phaseCnt, CAS_SETUP)) stateNext = ST_SELF_HOLD;
      ST_SELF_HOLD:
        if (!selfReq && phaseCnt >= CNT_W'(SELF_MIN - 1)) stateNext = ST_SELF_PRECH;
      ST_SELF_PRECH:
        if (atEnd(phaseCnt, SELF_PRECHARGE)) begin
          stateNext = ST_REQ;
          phaseNext = PH_POST;
        end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_INIT_WAIT;
      phase    <= PH_INIT;
      initDone <= 1'b0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
      if (prechEnd && phase == PH_INIT && initLast) initDone <= 1'b1;
    end
  end

  // strobes to the datapath
  assign ctl.cntClr  = (stateNext != state);
  assign ctl.tmrHold = !initDone || phase == PH_PRE || phase == PH_POST;
  assign ctl.pendDec = prechEnd && phase == PH_NORM;
  assign ctl.initInc = prechEnd && phase == PH_INIT;

  // memory strobes and status
  assign rasN = !(state == ST_RAS_ACT || state == ST_SELF_HOLD);
  assign casN = !(state == ST_CAS_SET || state == ST_SELF_SET || state == ST_SELF_HOLD ||
                  (state == ST_RAS_ACT && phaseCnt < CNT_W'(CAS_HOLD)));
  assign refReq = !(state == ST_IDLE || state == ST_INIT_WAIT);
  assign busy   = (state != ST_IDLE);
  assign inSelf = (state == ST_SELF_HOLD);

  assert_cas_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN)));

  assert_wait_grant_R5: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && rasN && casN && !grant && state == ST_REQ) |=> (rasN && casN));

  assert_self_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !inSelf);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int INIT_PAUSE     = 20000,
  parameter int INIT_CYCLES    = 8,
  parameter int REF_INTERVAL   = 1560,
  parameter int CAS_SETUP      = 2,
  parameter int CAS_HOLD       = 3,
  parameter int RAS_LOW        = 8,
  parameter int PRECHARGE      = 6,
  parameter int ZONE_LO        = 1000,
  parameter int SELF_MIN       = 10000,
  parameter int SELF_PRECHARGE = 13,
  parameter int MAX_PENDING    = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic grant,
  input  logic selfReq,
  output logic refReq,
  output logic rasN,
  output logic casN,
  output logic busy,
  output logic inSelf,
  output logic initDone
);

  localparam int CNT_W = $clog2(INIT_PAUSE + SELF_MIN + SELF_PRECHARGE + RAS_LOW + PRECHARGE + 2);
  localparam int RUN_W = $clog2(SELF_MIN + 2);

  dpCtl_t           ctl;
  logic [CNT_W-1:0] phaseCnt;
  logic             pendAny;
  logic             pendMulti;
  logic             initLast;

  ref_control #(
    .CNT_W(CNT_W), .INIT_PAUSE(INIT_PAUSE), .CAS_SETUP(CAS_SETUP), .CAS_HOLD(CAS_HOLD),
    .RAS_LOW(RAS_LOW), .PRECHARGE(PRECHARGE), .SELF_MIN(SELF_MIN),
    .SELF_PRECHARGE(SELF_PRECHARGE)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .grant(grant), .selfReq(selfReq),
    .phaseCnt(phaseCnt), .pendAny(pendAny), .pendMulti(pendMulti), .initLast(initLast),
    .ctl(ctl), .refReq(refReq), .rasN(rasN), .casN(casN), .busy(busy),
    .inSelf(inSelf), .initDone(initDone)
  );

  ref_datapath #(
    .CNT_W(CNT_W), .INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(REF_INTERVAL),
    .MAX_PENDING(MAX_PENDING)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .phaseCnt(phaseCnt),
    .pendAny(pendAny), .pendMulti(pendMulti), .initLast(initLast)
  );

  // row-strobe low run length, used only by the zone check below
  logic [RUN_W-1:0] lowRun;

  always_ff @(posedge clk) begin
    if (!rstN || rasN) lowRun <= '0;
    else if (lowRun != '1) lowRun <= lowRun + 1'b1;
  end

  assert_zone_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> (lowRun < RUN_W'(ZONE_LO) || lowRun >= RUN_W'(SELF_MIN)));

  assert_self_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    inSelf |-> (busy && refReq));

endmodule

// File: tb/tb_dram_refresh_seq.sv
module tb_dram_refresh_seq;

  localparam int CLK_PERIOD     = 10;
  localparam int INIT_PAUSE     = 20;
  localparam int INIT_CYCLES    = 8;
  localparam int REF_INTERVAL   = 100;
  localparam int CAS_SETUP      = 2;
  localparam int CAS_HOLD       = 2;
  localparam int RAS_LOW        = 4;
  localparam int PRECHARGE      = 3;
  localparam int ZONE_LO        = 10;
  localparam int SELF_MIN       = 30;
  localparam int SELF_PRECHARGE = 6;
  localparam int MAX_PENDING    = 4;
  localparam int WATCHDOG       = 20000;

  logic clk = 1'b0;
  logic rstN, grant, selfReq;
  logic refReq, rasN, casN, busy, inSelf, initDone;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_refresh_seq #(
    .INIT_PAUSE(INIT_PAUSE), .INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(REF_INTERVAL),
    .CAS_SETUP(CAS_SETUP), .CAS_HOLD(CAS_HOLD), .RAS_LOW(RAS_LOW), .PRECHARGE(PRECHARGE),
    .ZONE_LO(ZONE_LO), .SELF_MIN(SELF_MIN), .SELF_PRECHARGE(SELF_PRECHARGE),
    .MAX_PENDING(MAX_PENDING)
  ) dut (
    .clk(clk), .rstN(rstN), .grant(grant), .selfReq(selfReq), .refReq(refReq),
    .rasN(rasN), .casN(casN), .busy(busy), .inSelf(inSelf), .initDone(initDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- strobe monitor (samples on falling edge) ----------------
  int  cyc = 0;
  int  rasLen, casRun, sinceRise;
  int  rasFalls = 0, shortCnt = 0, longCnt = 0;
  bit  prevR, prevC, lastLong, shortSinceLong;

  always @(negedge clk) begin
    cyc++;
    if (!rstN) begin
      prevR = 1'b1; prevC = 1'b1; rasLen = 0; casRun = 0; sinceRise = 1000;
      lastLong = 1'b0; shortSinceLong = 1'b1;
    end else begin
      if (prevR && !rasN) begin
        rasFalls++;
        check(!casN && casRun == CAS_SETUP, "R3 cas setup before ras fall", casRun, CAS_SETUP);
        if (lastLong)
          check(sinceRise >= SELF_PRECHARGE + CAS_SETUP, "R9 self precharge",
                sinceRise, SELF_PRECHARGE + CAS_SETUP);
        else
          check(sinceRise >= PRECHARGE + CAS_SETUP, "R3 precharge", sinceRise,
                PRECHARGE + CAS_SETUP);
      end
      if (!prevR && rasN) begin
        check(rasLen < ZONE_LO || rasLen >= SELF_MIN, "R8 transition zone", rasLen, SELF_MIN);
        if (rasLen < ZONE_LO) begin
          check(rasLen == RAS_LOW, "R3 refresh ras low length", rasLen, RAS_LOW);
          shortCnt++;
          shortSinceLong = 1'b1;
          lastLong = 1'b0;
        end else begin
          check(shortSinceLong, "R11 refresh between self periods", shortSinceLong, 1);
          longCnt++;
          shortSinceLong = 1'b0;
          lastLong = 1'b1;
        end
        sinceRise = 0;
      end
      if (!prevC && casN && !rasN)
        check(rasLen == CAS_HOLD, "R3 cas hold after ras fall", rasLen, CAS_HOLD);
      rasLen = rasN ? 0 : rasLen + 1;
      casRun = casN ? 0 : casRun + 1;
      if (rasN) sinceRise++;
      prevR = rasN;
      prevC = casN;
    end
  end

  // ---------------- helpers ----------------
  int relCyc;

  task automatic applyReset(input logic selfLevel);
    rstN = 1'b0; grant = 1'b1; selfReq = selfLevel;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    relCyc = cyc;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400 && (busy || refReq); i++) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    rstN = 1'b0; grant = 1'b0; selfReq = 1'b0;
    repeat (3) @(negedge clk);
    check(rasN && casN, "R1 strobes high in reset", {rasN, casN}, 3);
    check(!refReq && !initDone && !inSelf, "R1 status low in reset",
          {refReq, initDone, inSelf}, 0);
    grant = 1'b1;
    rstN = 1'b1;
    relCyc = cyc;
    @(negedge clk);
    check(busy && !refReq && rasN && casN, "R1 first cycle after reset",
          {busy, refReq, rasN, casN}, 4'b1011);
  endtask

  task automatic testInit();
    int base;
    base = rasFalls;
    for (int i = 0; i < 200 && casN; i++) @(negedge clk);
    check(cyc - relCyc >= INIT_PAUSE, "R2 initial pause", cyc - relCyc, INIT_PAUSE);
    for (int i = 0; i < 500 && !initDone; i++) @(negedge clk);
    check(initDone, "R2 initDone rises", initDone, 1);
    check(rasFalls - base == INIT_CYCLES, "R2 init burst count", rasFalls - base, INIT_CYCLES);
  endtask

  task automatic testInterval();
    int base;
    base = rasFalls;
    repeat (5 * REF_INTERVAL + 20) @(negedge clk);
    check(rasFalls - base == 5, "R4 one refresh per interval", rasFalls - base, 5);
    check(initDone, "R2 initDone stays high", initDone, 1);
  endtask

  task automatic testGrantBurst();
    int base;
    waitIdle();
    grant = 1'b0;
    for (int i = 0; i < 2 * REF_INTERVAL && !refReq; i++) @(negedge clk);
    check(refReq, "R5 request on due refresh", refReq, 1);
    base = rasFalls;
    repeat (550) @(negedge clk);
    check(rasFalls == base, "R5 no strobe without grant", rasFalls - base, 0);
    check(refReq && rasN && casN, "R5 waiting with strobes high", {refReq, rasN, casN}, 7);
    grant = 1'b1;
    repeat (45) @(negedge clk);
    check(rasFalls - base == MAX_PENDING, "R6 capped burst", rasFalls - base, MAX_PENDING);
    check(!refReq, "R5 request released when idle", refReq, 0);
  endtask

  task automatic testSelfShort();
    int base, len;
    waitIdle();
    selfReq = 1'b1;
    base = shortCnt;
    for (int i = 0; i < 100 && !inSelf; i++) @(negedge clk);
    check(inSelf, "R7 self entry", inSelf, 1);
    check(shortCnt - base == 1, "R7 one refresh before entry", shortCnt - base, 1);
    check(!rasN && !casN && busy, "R7 both strobes low", {rasN, casN, busy}, 1);
    repeat (2) @(negedge clk);
    selfReq = 1'b0;
    len = 3;
    for (int i = 0; i < 200 && inSelf; i++) begin
      @(negedge clk);
      if (inSelf) len++;
    end
    check(len == SELF_MIN, "R7 minimum self period", len, SELF_MIN);
    base = shortCnt;
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    check(!busy && !inSelf, "R9 busy ends after sequence", {busy, inSelf}, 0);
    check(shortCnt - base == 1, "R9 one refresh after exit", shortCnt - base, 1);
  endtask

  task automatic testSelfLong();
    int base, waitN;
    waitIdle();
    selfReq = 1'b1;
    for (int i = 0; i < 100 && !inSelf; i++) @(negedge clk);
    repeat (60) @(negedge clk);
    check(inSelf && !rasN && !casN && busy, "R7 held while requested",
          {inSelf, rasN, casN, busy}, 4'b1001);
    selfReq = 1'b0;
    waitN = 0;
    for (int i = 0; i < 10 && inSelf; i++) begin
      @(negedge clk);
      waitN++;
    end
    check(waitN <= 2 && !inSelf, "R7 prompt exit after long hold", waitN, 1);
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
    // request again at once: a fresh refresh must precede the next period
    selfReq = 1'b1;
    base = shortCnt;
    for (int i = 0; i < 100 && !inSelf; i++) @(negedge clk);
    check(inSelf && shortCnt - base == 1, "R11 refresh before repeated entry",
          shortCnt - base, 1);
    selfReq = 1'b0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    check(!busy, "R9 busy cleared after second period", busy, 0);
  endtask

  task automatic testSelfBeforeInit();
    int longBase, base;
    bit sawSelf;
    longBase = longCnt;
    sawSelf = 1'b0;
    applyReset(1'b1);
    for (int i = 0; i < 500 && !initDone; i++) begin
      @(negedge clk);
      if (inSelf && !initDone) sawSelf = 1'b1;
    end
    check(!sawSelf, "R10 no self-refresh before init", sawSelf, 0);
    check(longCnt == longBase, "R10 only short pulses during init", longCnt - longBase, 0);
    base = shortCnt;
    for (int i = 0; i < 100 && !inSelf; i++) @(negedge clk);
    check(inSelf && shortCnt - base == 1, "R10 request served after init",
          shortCnt - base, 1);
    selfReq = 1'b0;
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    check(!busy, "R9 busy cleared", busy, 0);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual %0d expected below %0d", WATCHDOG, WATCHDOG);
    finishRun();
  end

  initial begin
    testReset();
    testInit();
    testInterval();
    testGrantBurst();
    testSelfShort();
    testSelfLong();
    testSelfBeforeInit();
    finishRun();
  end

endmodule